// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire bus slave that exposes a small bank of 8-bit configuration registers, such as per-output clock enable bits, to a bus master. The registers come out of reset holding parameterised default values and drive a flat parallel output bus, so the surrounding logic runs correctly even if the bus is never used. A master may change them at system start-up with byte writes or block writes and can read them back with byte reads or block reads.

SCL and SDA are sampled by the system clock through a short synchroniser. START and STOP are decoded from SDA edges while SCL is high. Incoming bits are captured on SCL rising edges. The slave only changes its open-drain SDA enable after an SCL falling edge. The command byte that follows the address selects the transfer style. With its top bit set, the low seven bits are the register offset for a single-byte access. With its top bit clear, the access is a block transfer that always begins at register zero. Writes are committed one byte at a time, so a master may stop a block transfer after any complete byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: While reset is held and right after it, every register shows its value from the `RESET_VAL` parameter (register n in bits 8n+7:8n of `regs_o`) and `sda_oe` is 0.
- R2: The slave pulls SDA low in the ninth clock (ACK, `sda_oe`=1) only for the 7-bit address 0x69 (write byte 0xD2, read byte 0xD3). For any other address it leaves SDA released (NACK) and no register changes.
- R3: A byte write (address 0xD2, command with bit 7 = 1 and offset in bits 6:0, one data byte, all MSB first) stores the data in that register only. A further data byte in the same transfer is NACKed and ignored.
- R4: A byte-mode command whose offset is not below `NUM_REGS` is NACKed, and the data that follows changes no register.
- R5: A block write (command 0x00, then a byte-count byte, then data) stores data bytes into registers 0, 1, 2 and onward. A STOP after any complete data byte keeps the bytes already written and leaves the higher registers untouched. Register contents change only while SCL is low.
- R6: A block command (bit 7 = 0) with any of bits 6:0 set is NACKed, and the transfer changes no register.
- R7: After a byte-mode command, a repeated START with read address 0xD3 makes the slave return the addressed register MSB first.
- R8: After command 0x00, a repeated START with 0xD3 returns first a count byte equal to `NUM_REGS`, then registers 0, 1, 2 and onward. When the master NACKs a byte the slave releases SDA and stays off the bus until the next START.
- R9: A STOP or START that arrives inside a byte abandons that byte without writing it. A START restarts the address phase, and a complete transfer after it behaves normally.
- R10: In a block write, data bytes beyond the last register are NACKed and do not alter any register.
- R11: `sda_oe` is only changed while SCL is low, and each change follows an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, sampling the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| regs_o | output | NUM_REGS*8 | Register file contents, register n in bits 8n+7:8n |

## Verification
The assertions check the timing rules on every cycle. SDA drive only rises or moves while SCL is low, at most one register changes in any cycle, register contents only move while SCL is low, and the reset values hold during reset. Only the bench's scenarios can show the protocol outcomes. These include which bytes are acknowledged (good and bad addresses, offsets out of range, block commands with stray low bits, a block write running past the last register) and the data and count bytes returned by byte and block reads. They also cover the effect of a STOP or repeated START in the middle of a byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_WAIT
    } smb_state_e;

    typedef enum logic [2:0] {
        ROLE_ADDR,
        ROLE_CMD,
        ROLE_CNT,
        ROLE_DATA,
        ROLE_DONE
    } smb_role_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_now;

    // Idle bus is high on both lines, so every stage resets to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe_q[STAGES-1];
    assign sda_lvl   = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_now & ~scl_prev_q;
    assign scl_fall  = ~scl_now & scl_prev_q;
    assign start_evt = scl_now & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_evt  = scl_now & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                    NUM_REGS  = 8,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    logic [7:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RESET_VAL[g*8 +: 8];
            end else if (wr_en && (wr_idx == 8'(g))) begin
                regs_q[g] <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = regs_q[g];
    end

    // Offsets past the bank read as zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 8'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int                    NUM_REGS    = 8,
    parameter logic [6:0]            DEV_ADDR    = 7'h69,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL   = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

    typedef struct packed {
        smb_state_e state;
        smb_role_e  role;
        logic [3:0] bit_cnt;
        logic [7:0] shreg;
        logic [7:0] ptr;
        logic       is_read;
        logic       byte_mode;
        logic       cnt_sent;
        logic       master_nack;
        logic       oe;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:       ST_IDLE,
        role:        ROLE_ADDR,
        bit_cnt:     4'd0,
        shreg:       8'h00,
        ptr:         8'h00,
        is_read:     1'b0,
        byte_mode:   1'b0,
        cnt_sent:    1'b0,
        master_nack: 1'b0,
        oe:          1'b0
    };

    ctl_t       c_q, c_d;
    logic       sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic       wr_en;
    logic [7:0] rd_data;
    logic [7:0] tx_byte;
    logic [7:0] ptr_inc;
    logic       send_count;
    logic       accept;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_line_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    smb_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .RESET_VAL (RESET_VAL)
    ) u_reg_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (c_q.ptr),
        .wr_data   (c_q.shreg),
        .rd_idx    (c_q.ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    // A block read sends the count once, then walks the registers.
    assign send_count = !c_q.byte_mode && !c_q.cnt_sent;
    assign tx_byte    = send_count ? REG_LIMIT : rd_data;
    assign ptr_inc    = c_q.ptr + ((c_q.ptr < REG_LIMIT) ? 8'd1 : 8'd0);

    always_comb begin
        c_d    = c_q;
        wr_en  = 1'b0;
        accept = 1'b0;

        if (start_evt) begin
            c_d.state    = ST_RX;
            c_d.role     = ROLE_ADDR;
            c_d.bit_cnt  = 4'd0;
            c_d.oe       = 1'b0;
            c_d.cnt_sent = 1'b0;
        end else if (stop_evt) begin
            c_d.state = ST_IDLE;
            c_d.oe    = 1'b0;
        end else begin
            case (c_q.state)
                ST_RX: begin
                    if (scl_rise && (c_q.bit_cnt < 4'd8)) begin
                        c_d.shreg   = {c_q.shreg[6:0], sda_lvl};
                        c_d.bit_cnt = c_q.bit_cnt + 4'd1;
                    end else if (scl_fall && (c_q.bit_cnt == 4'd8)) begin
                        case (c_q.role)
                            ROLE_ADDR: begin
                                if (c_q.shreg[7:1] == DEV_ADDR) begin
                                    accept      = 1'b1;
                                    c_d.is_read = c_q.shreg[0];
                                    c_d.role    = ROLE_CMD;
                                end
                            end
                            ROLE_CMD: begin
                                if (c_q.shreg[7]) begin
                                    if ({1'b0, c_q.shreg[6:0]} < REG_LIMIT) begin
                                        accept        = 1'b1;
                                        c_d.byte_mode = 1'b1;
                                        c_d.ptr       = {1'b0, c_q.shreg[6:0]};
                                        c_d.role      = ROLE_DATA;
                                    end
                                end else if (c_q.shreg[6:0] == 7'd0) begin
                                    accept        = 1'b1;
                                    c_d.byte_mode = 1'b0;
                                    c_d.ptr       = 8'd0;
                                    c_d.role      = ROLE_CNT;
                                end
                            end
                            ROLE_CNT: begin
                                accept   = 1'b1;
                                c_d.role = ROLE_DATA;
                            end
                            ROLE_DATA: begin
                                if (c_q.ptr < REG_LIMIT) begin
                                    accept  = 1'b1;
                                    wr_en   = 1'b1;
                                    c_d.ptr = ptr_inc;
                                    if (c_q.byte_mode) begin
                                        c_d.role = ROLE_DONE;
                                    end
                                end
                            end
                            default: accept = 1'b0;
                        endcase
                        c_d.state = accept ? ST_ACK : ST_WAIT;
                        c_d.oe    = accept;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        c_d.bit_cnt = 4'd0;
                        if (c_q.is_read) begin
                            c_d.state = ST_TX;
                            c_d.shreg = tx_byte;
                            c_d.oe    = ~tx_byte[7];
                            if (send_count) begin
                                c_d.cnt_sent = 1'b1;
                            end else begin
                                c_d.ptr = ptr_inc;
                            end
                        end else begin
                            c_d.state = ST_RX;
                            c_d.oe    = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (c_q.bit_cnt == 4'd7) begin
                            c_d.state = ST_RACK;
                            c_d.oe    = 1'b0;
                        end else begin
                            c_d.bit_cnt = c_q.bit_cnt + 4'd1;
                            c_d.shreg   = {c_q.shreg[6:0], 1'b0};
                            c_d.oe      = ~c_q.shreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        c_d.master_nack = sda_lvl;
                    end else if (scl_fall) begin
                        c_d.bit_cnt = 4'd0;
                        if (c_q.master_nack) begin
                            c_d.state = ST_WAIT;
                            c_d.oe    = 1'b0;
                        end else begin
                            c_d.state = ST_TX;
                            c_d.shreg = tx_byte;
                            c_d.oe    = ~tx_byte[7];
                            if (send_count) begin
                                c_d.cnt_sent = 1'b1;
                            end else begin
                                c_d.ptr = ptr_inc;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTL_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe = c_q.oe;

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
    parameter int                    NUM_REGS  = 8,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = '1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs_o
);
    logic [NUM_REGS*8-1:0] regs_prev_q;
    logic [NUM_REGS-1:0]   reg_moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_prev_q <= RESET_VAL;
        end else begin
            regs_prev_q <= regs_o;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_moved
        assign reg_moved[g] = regs_o[g*8 +: 8] != regs_prev_q[g*8 +: 8];
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_STATE: assert (regs_o == RESET_VAL && !sda_oe) else $error("reset state wrong"); // R1
        end
    end

    AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reg_moved)) else $error("several registers moved"); // R3

    AST_WRITE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(regs_o) |-> !scl_i) else $error("register moved with SCL high"); // R5

    AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_i) else $error("SDA drive began with SCL high"); // R11

    AST_DRIVE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (scl_i && $past(scl_i)) |-> $stable(sda_oe)) else $error("SDA drive moved with SCL high"); // R11

endmodule

bind smb_cfg_slave smb_cfg_checker #(
    .NUM_REGS  (NUM_REGS),
    .RESET_VAL (RESET_VAL)
) u_smb_cfg_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .regs_o (regs_o)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;
    localparam int Q          = 6;

    function automatic logic [NREG*8-1:0] mk_defaults();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = 8'(8'hC0 + i * 3);
        return v;
    endfunction
    localparam logic [NREG*8-1:0] DEFAULTS = mk_defaults();

    typedef struct {
        string       tag;
        logic [63:0] val;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              m_scl = 1'b1;
    logic              m_sda = 1'b1;
    logic              sda_oe;
    logic              sda_line;
    logic [NREG*8-1:0] regs_o;

    logic [7:0] model [NREG];
    item_t      exp_q[$];
    item_t      obs_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] rx_exp_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    int         oe_violations = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave #(
        .NUM_REGS  (NREG),
        .RESET_VAL (DEFAULTS)
    ) i_smb_cfg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(string tag, logic [63:0] v);
        exp_q.push_back('{tag: tag, val: v});
    endtask

    task automatic observe(logic [63:0] v);
        obs_q.push_back('{tag: "", val: v});
    endtask

    // Monitor: pairs each observation with the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                item_t o;
                item_t e;
                o = obs_q.pop_front();
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected observation actual %h expected none", o.val);
                end else begin
                    e = exp_q.pop_front();
                    if (o.val !== e.val) begin
                        n_fail++;
                        $display("FAIL %s actual %h expected %h", e.tag, o.val, e.val);
                    end
                end
            end
        end
    end

    // R11 bench view: the drive enable never moves while SCL stays high.
    initial begin
        logic prev_oe;
        logic prev_scl;
        prev_oe  = 1'b0;
        prev_scl = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && (sda_oe !== prev_oe) && m_scl && prev_scl) oe_violations++;
            prev_oe  = sda_oe;
            prev_scl = m_scl;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    // Sends a byte and scores the ninth bit: 0 = ACK, 1 = NACK.
    task automatic send_byte_chk(string tag, logic [7:0] v, logic exp_nack, output logic nack);
        expect_item(tag, 64'(exp_nack));
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(nack);
        observe(64'(nack));
    endtask

    task automatic recv_byte_chk(string tag, logic [7:0] exp_v, logic last);
        logic [7:0] v;
        expect_item(tag, 64'(exp_v));
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        send_bit(last);
        observe(64'(v));
    endtask

    // Write transfer from tx_q; the first n_ack bytes are expected to be ACKed.
    task automatic wr_txn(string tag, int n_ack);
        bus_start();
        for (int i = 0; i < tx_q.size(); i++) begin
            logic nack;
            send_byte_chk(tag, tx_q[i], (i >= n_ack), nack);
            if (nack) break;
        end
        bus_stop();
        tick(4);
    endtask

    task automatic rd_txn(string tag, logic [7:0] cmd);
        logic nack;
        bus_start();
        send_byte_chk(tag, 8'hD2, 1'b0, nack);
        send_byte_chk(tag, cmd, 1'b0, nack);
        bus_start();
        send_byte_chk(tag, 8'hD3, 1'b0, nack);
        for (int i = 0; i < rx_exp_q.size(); i++) begin
            recv_byte_chk(tag, rx_exp_q[i], (i == rx_exp_q.size() - 1));
        end
        bus_stop();
        tick(4);
    endtask

    task automatic chk_regs(string tag);
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        expect_item(tag, 64'(v));
        tick(2);
        observe(64'(regs_o));
    endtask

    task automatic chk_released(string tag);
        expect_item(tag, 64'd0);
        observe(64'(sda_oe));
    endtask

    initial begin
        logic nack;
        for (int i = 0; i < NREG; i++) model[i] = DEFAULTS[i*8 +: 8];
        tick(5);
        chk_regs("R1 reset values");
        chk_released("R1 sda_oe in reset");
        rst_n = 1'b1;
        tick(5);
        chk_regs("R1 values after reset");

        // R3 byte write to offset 3
        tx_q = {8'hD2, 8'h83, 8'hA5};
        wr_txn("R3 byte write ack", 3);
        model[3] = 8'hA5;
        chk_regs("R3 byte write result");

        // R3 extra data byte after a byte write is NACKed
        tx_q = {8'hD2, 8'h84, 8'h66, 8'h77};
        wr_txn("R3 extra byte nack", 3);
        model[4] = 8'h66;
        chk_regs("R3 only addressed register");

        // R7 byte reads
        rx_exp_q = {8'hA5};
        rd_txn("R7 byte read offset 3", 8'h83);
        rx_exp_q = {model[5]};
        rd_txn("R7 byte read offset 5", 8'h85);

        // R2 foreign addresses
        tx_q = {8'hA4, 8'h81, 8'h00};
        wr_txn("R2 address 0x52 nack", 0);
        tx_q = {8'hD0, 8'h81, 8'h00};
        wr_txn("R2 address 0x68 nack", 0);
        chk_regs("R2 no change after foreign address");

        // R4 offset out of range
        tx_q = {8'hD2, 8'h88, 8'h55};
        wr_txn("R4 offset 8 nack", 1);
        tx_q = {8'hD2, 8'hFF, 8'h55};
        wr_txn("R4 offset 127 nack", 1);
        chk_regs("R4 no change");

        // R6 block command with stray low bits
        tx_q = {8'hD2, 8'h05, 8'h03, 8'h77};
        wr_txn("R6 block cmd 0x05 nack", 1);
        chk_regs("R6 no change");

        // R5 block writes, full count and early stop
        tx_q = {8'hD2, 8'h00, 8'h03, 8'h11, 8'h22, 8'h33};
        wr_txn("R5 block write ack", 6);
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        chk_regs("R5 block write result");
        tx_q = {8'hD2, 8'h00, 8'h08, 8'h44};
        wr_txn("R5 early stop ack", 4);
        model[0] = 8'h44;
        chk_regs("R5 early stop keeps byte");

        // R10 block write past the last register
        tx_q = {8'hD2, 8'h00, 8'h09};
        for (int i = 0; i < NREG; i++) tx_q.push_back(8'(8'hA0 + i));
        tx_q.push_back(8'hEE);
        wr_txn("R10 past end nack", 3 + NREG);
        for (int i = 0; i < NREG; i++) model[i] = 8'(8'hA0 + i);
        chk_regs("R10 registers after overrun");

        // R8 block read, full and partial
        rx_exp_q = {8'(NREG)};
        for (int i = 0; i < NREG; i++) rx_exp_q.push_back(model[i]);
        rd_txn("R8 block read", 8'h00);
        chk_released("R8 sda released after nack");
        rx_exp_q = {8'(NREG), model[0], model[1]};
        rd_txn("R8 partial block read", 8'h00);
        chk_released("R8 released after partial");

        // R9 stop inside a data byte
        bus_start();
        send_byte_chk("R9 abort addr", 8'hD2, 1'b0, nack);
        send_byte_chk("R9 abort cmd", 8'h81, 1'b0, nack);
        for (int i = 7; i >= 4; i--) send_bit(i[0]);
        bus_stop();
        tick(4);
        chk_regs("R9 stop mid byte no write");

        // R9 repeated start inside a data byte, then a normal transfer
        bus_start();
        send_byte_chk("R9 restart addr", 8'hD2, 1'b0, nack);
        send_byte_chk("R9 restart cmd", 8'h82, 1'b0, nack);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte_chk("R9 new addr", 8'hD2, 1'b0, nack);
        send_byte_chk("R9 new cmd", 8'h82, 1'b0, nack);
        send_byte_chk("R9 new data", 8'h5A, 1'b0, nack);
        bus_stop();
        tick(4);
        model[2] = 8'h5A;
        chk_regs("R9 write after restart");

        expect_item("R11 drive moved with SCL high", 64'd0);
        observe(64'(oe_violations));

        tick(10);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard actual %0d pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule